// File: doc/BRIEF.md
# Four-Channel Memory Copy Engine

This block copies data between memory locations without the processor doing the work. It has four independent channels. Each channel holds a source address, a destination address, a unit count and a 16-bit control word, and these are written through a small configuration port and read back through a separate read port. A started channel moves its units one at a time over a single-master memory port. Each unit is either 16 or 32 bits, and each unit is a read followed by a write. When the last unit is written, the channel updates its stored addresses, may turn itself off, and may raise a one-cycle interrupt.

Software starts a channel by turning on its enable bit while the start field is 0. Channels 1 and 2 can also be armed as audio-buffer refillers (start field 3). An armed refiller waits for a pulse on its own request line. It then moves exactly four 32-bit units into one fixed destination, whatever the width, count and destination-step fields say. Only one channel runs at a time. When the engine is free, the lowest-numbered waiting channel goes next.

Control word layout: bit 15 enable, bit 14 interrupt enable, bits 13:12 start field, bit 10 unit size (1 = 32-bit), bit 9 repeat, bits 8:7 source step, bits 6:5 destination step. Configuration selector: 0 source, 1 destination, 2 count, 3 control.

Top module: `dma_engine`

## Requirements
- R1: After reset, every stored register reads 0, `mem_req` is low and `irq` is 0.
- R2: Writing a control word whose enable bit changes from 0 to 1, with the start field at 0, starts the channel. Each unit reads from the source and then writes to the destination. Each access holds `mem_req` until `mem_ready`. For a 16-bit unit, `mem_wdata` carries the low half of the read data and zeros above it. Rewriting the control word while the enable bit is already 1 does not start a transfer.
- R3: Source step field (bits 8:7): 0 adds the unit size (4 for 32-bit, 2 for 16-bit) after each unit, 1 subtracts it, and 2 or 3 keeps the address fixed.
- R4: Destination step field (bits 6:5): 0 adds the unit size, 1 subtracts it, and 2 keeps the address fixed. Value 3 adds the unit size, but the stored destination register keeps its programmed value after the transfer.
- R5: The count register is used modulo 2^14 on channels 0-2 and modulo 2^16 on channel 3. A used count of 0 means 0x4000 units (channels 0-2) or 0x10000 units (channel 3).
- R6: Addresses are cut to 27 bits for channel 0 source and destination, 28/27 bits for the source/destination of channels 1 and 2, and 28 bits for both on channel 3. This masking applies to the bus address and to the written-back value.
- R7: At the end of a transfer, the stored source becomes the next source address and, unless the destination step is 3, the stored destination becomes the next destination address. The enable bit is cleared unless the repeat bit (bit 9) is set.
- R8: If bit 14 is set, `irq[ch]` is high for exactly the one cycle after the last write is accepted. It stays low if bit 14 is clear.
- R9: On channel 1 or 2 with start field 3, a pulse on `fifo_req[ch-1]` runs exactly four 32-bit units to a fixed destination, ignoring the width, count and destination-step fields. Enabling the channel alone does not start it. With repeat set, each further pulse runs again.
- R10: Start field 3 on channel 0 never causes any memory access or interrupt.
- R11: When several channels are waiting, they run one at a time and the lowest-numbered channel runs first. A running transfer is never interrupted.
- R12: While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_we` and `mem_addr` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 2 | Channel addressed by the write |
| cfg_sel | input | 2 | Register selected: 0 src, 1 dst, 2 count, 3 control |
| cfg_wdata | input | 32 | Write data (count and control use the low 16 bits) |
| rd_ch | input | 2 | Channel for readback |
| rd_sel | input | 2 | Register for readback |
| rd_data | output | 32 | Readback value, combinational |
| fifo_req | input | 2 | Refill requests for channels 1 and 2 |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_wide | output | 1 | 1 = 32-bit unit, 0 = 16-bit unit |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` on a read |
| mem_ready | input | 1 | Access accepted this cycle |
| irq | output | 4 | Per-channel end-of-transfer pulse |

## Verification
A channel started by a configuration write is granted on the first clock edge after that write lands. Its first read request then appears one cycle after the grant. Each write is checked in the scoreboard in the exact cycle it is accepted, with `mem_req`, `mem_we` and `mem_ready` all high, so an irregular ready pattern does not move any check. The interrupt pulse appears in the cycle after the last write is accepted. The stored addresses and enable bit update on the edge that ends that pulse, so readback checks are made only after the scoreboard has drained and several further idle cycles have passed.

// File: rtl/dma_pkg.sv
package dma_pkg;

    localparam int NCH    = 4;
    localparam int AW     = 32;
    localparam int CW     = 17;
    localparam int CH_W   = $clog2(NCH);

    // control word bit positions
    localparam int CB_EN   = 15;
    localparam int CB_IE   = 14;
    localparam int CB_ST   = 12;
    localparam int CB_WIDE = 10;
    localparam int CB_RPT  = 9;
    localparam int CB_SM   = 7;
    localparam int CB_DM   = 5;

    typedef enum logic [1:0] {SEL_SRC, SEL_DST, SEL_CNT, SEL_CTRL} reg_sel_e;
    typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_DONE} xfer_state_e;

    typedef struct packed {
        logic [CH_W-1:0] ch;
        logic [AW-1:0]   src;
        logic [AW-1:0]   dst;
        logic [AW-1:0]   sstep;
        logic [AW-1:0]   dstep;
        logic [AW-1:0]   smask;
        logic [AW-1:0]   dmask;
        logic [CW-1:0]   count;
        logic            wide;
        logic            reload;
        logic            rpt;
        logic            irq_en;
        logic            fifo;
    } xfer_desc_t;

    function automatic int src_bits(input int ch);
        return (ch == 0) ? 27 : 28;
    endfunction

    function automatic int dst_bits(input int ch);
        return (ch == 3) ? 28 : 27;
    endfunction

    function automatic int cnt_bits(input int ch);
        return (ch == 3) ? 16 : 14;
    endfunction

    function automatic bit fifo_capable(input int ch);
        return (ch == 1) || (ch == 2);
    endfunction

    function automatic logic [AW-1:0] bit_mask(input int bits);
        return (AW'(1) << bits) - AW'(1);
    endfunction

    function automatic xfer_desc_t make_desc(input logic [CH_W-1:0] ch,
                                             input logic [AW-1:0] src,
                                             input logic [AW-1:0] dst,
                                             input logic [15:0] cnt,
                                             input logic [15:0] ctrl);
        xfer_desc_t    d;
        logic [AW-1:0] unit;
        logic [CW-1:0] c;
        logic [1:0]    sm, dm;
        int            chi;
        chi      = int'(ch);
        sm       = ctrl[CB_SM +: 2];
        dm       = ctrl[CB_DM +: 2];
        d.ch     = ch;
        d.fifo   = (ctrl[CB_ST +: 2] == 2'd3) && fifo_capable(chi);
        d.wide   = d.fifo | ctrl[CB_WIDE];
        unit     = d.wide ? AW'(4) : AW'(2);
        d.smask  = bit_mask(src_bits(chi));
        d.dmask  = bit_mask(dst_bits(chi));
        d.src    = src & d.smask;
        d.dst    = dst & d.dmask;
        case (sm)
            2'd0:    d.sstep = unit;
            2'd1:    d.sstep = -unit;
            default: d.sstep = '0;
        endcase
        if (d.fifo) d.dstep = '0;
        else begin
            case (dm)
                2'd1:    d.dstep = -unit;
                2'd2:    d.dstep = '0;
                default: d.dstep = unit;
            endcase
        end
        c = CW'(cnt) & ((CW'(1) << cnt_bits(chi)) - CW'(1));
        if (d.fifo)        d.count = CW'(4);
        else if (c == '0)  d.count = CW'(1) << cnt_bits(chi);
        else               d.count = c;
        d.reload = (dm == 2'd3);
        d.rpt    = ctrl[CB_RPT];
        d.irq_en = ctrl[CB_IE];
        return d;
    endfunction

endpackage

// File: rtl/dma_regs.sv
module dma_regs
    import dma_pkg::*;
#(
    parameter int N = NCH
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [CH_W-1:0]      cfg_ch,
    input  logic [1:0]           cfg_sel,
    input  logic [AW-1:0]        cfg_wdata,
    input  logic [1:0]           fifo_req,
    input  logic [N-1:0]         grant,
    input  logic                 wb_valid,
    input  logic [CH_W-1:0]      wb_ch,
    input  logic [AW-1:0]        wb_src,
    input  logic [AW-1:0]        wb_dst,
    input  logic                 wb_reload,
    input  logic                 wb_clr_en,
    output logic [AW-1:0]        src_q  [N],
    output logic [AW-1:0]        dst_q  [N],
    output logic [15:0]          cnt_q  [N],
    output logic [15:0]          ctrl_q [N],
    output logic [N-1:0]         pend
);

    for (genvar i = 0; i < N; i++) begin : g_ch
        localparam bit HAS_FIFO = fifo_capable(i);
        logic wr_hit, wb_hit, fifo_hit, wr_ctrl;

        assign wr_hit  = cfg_we && (cfg_ch == CH_W'(i));
        assign wr_ctrl = wr_hit && (reg_sel_e'(cfg_sel) == SEL_CTRL);
        assign wb_hit  = wb_valid && (wb_ch == CH_W'(i));

        if (HAS_FIFO) begin : g_fifo
            assign fifo_hit = fifo_req[i-1] && ctrl_q[i][CB_EN]
                              && (ctrl_q[i][CB_ST +: 2] == 2'd3);
        end else begin : g_nofifo
            assign fifo_hit = 1'b0;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                src_q[i]  <= '0;
                dst_q[i]  <= '0;
                cnt_q[i]  <= '0;
                ctrl_q[i] <= '0;
                pend[i]   <= 1'b0;
            end else begin
                if (wb_hit) begin
                    src_q[i] <= wb_src;
                    if (!wb_reload) dst_q[i] <= wb_dst;
                    if (wb_clr_en)  ctrl_q[i][CB_EN] <= 1'b0;
                end
                if (wr_hit) begin
                    case (reg_sel_e'(cfg_sel))
                        SEL_SRC:  src_q[i]  <= cfg_wdata;
                        SEL_DST:  dst_q[i]  <= cfg_wdata;
                        SEL_CNT:  cnt_q[i]  <= cfg_wdata[15:0];
                        default:  ctrl_q[i] <= cfg_wdata[15:0];
                    endcase
                end
                if (grant[i] || (wb_hit && wb_clr_en)) pend[i] <= 1'b0;
                else if (wr_ctrl)
                    pend[i] <= (cfg_wdata[CB_EN] && !ctrl_q[i][CB_EN]
                                && (cfg_wdata[CB_ST +: 2] == 2'd0))
                               || (pend[i] && cfg_wdata[CB_EN]);
                else if (fifo_hit) pend[i] <= 1'b1;
            end
        end

        AST_PEND_HAS_EN: assert property (@(posedge clk) disable iff (rst)
            pend[i] |-> ctrl_q[i][CB_EN]); // R7
    end

endmodule

// File: rtl/dma_arbiter.sv
module dma_arbiter #(
    parameter int N   = 4,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  pend,
    input  logic          idle,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] gnt_id,
    output logic          gnt_valid
);

    always_comb begin
        gnt_id = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) gnt_id = IW'(i);
        end
        gnt_valid = idle && (|pend);
        grant     = gnt_valid ? (N'(1) << gnt_id) : '0;
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant)); // R11
    AST_GRANT_PENDING: assert property (@(posedge clk) disable iff (rst)
        (grant & ~pend) == '0); // R11

endmodule

// File: rtl/dma_xfer.sv
module dma_xfer
    import dma_pkg::*;
#(
    parameter int N = NCH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  xfer_desc_t        desc,
    output logic              idle,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_wide,
    output logic [AW-1:0]     mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ready,
    output logic              wb_valid,
    output logic [CH_W-1:0]   wb_ch,
    output logic [AW-1:0]     wb_src,
    output logic [AW-1:0]     wb_dst,
    output logic              wb_reload,
    output logic              wb_clr_en,
    output logic [N-1:0]      irq
);

    xfer_state_e   state;
    xfer_desc_t    d_q;
    logic [AW-1:0] cur_src, cur_dst;
    logic [CW-1:0] remain;
    logic [31:0]   data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            d_q     <= '0;
            cur_src <= '0;
            cur_dst <= '0;
            remain  <= '0;
            data_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    d_q     <= desc;
                    cur_src <= desc.src;
                    cur_dst <= desc.dst;
                    remain  <= desc.count;
                    state   <= ST_RD;
                end
                ST_RD: if (mem_ready) begin
                    data_q  <= d_q.wide ? mem_rdata : {16'h0, mem_rdata[15:0]};
                    cur_src <= (cur_src + d_q.sstep) & d_q.smask;
                    state   <= ST_WR;
                end
                ST_WR: if (mem_ready) begin
                    cur_dst <= (cur_dst + d_q.dstep) & d_q.dmask;
                    remain  <= remain - CW'(1);
                    state   <= (remain == CW'(1)) ? ST_DONE : ST_RD;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign idle      = (state == ST_IDLE);
    assign mem_req   = (state == ST_RD) || (state == ST_WR);
    assign mem_we    = (state == ST_WR);
    assign mem_wide  = d_q.wide;
    assign mem_addr  = (state == ST_WR) ? cur_dst : cur_src;
    assign mem_wdata = data_q;
    assign wb_valid  = (state == ST_DONE);
    assign wb_ch     = d_q.ch;
    assign wb_src    = cur_src;
    assign wb_dst    = cur_dst;
    assign wb_reload = d_q.reload;
    assign wb_clr_en = !d_q.rpt;
    assign irq       = (wb_valid && d_q.irq_en) ? (N'(1) << d_q.ch) : '0;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R12
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        (|irq) |=> (irq == '0)); // R8
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(irq)); // R8

endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_ch,
    input  logic [1:0]  cfg_sel,
    input  logic [31:0] cfg_wdata,
    input  logic [1:0]  rd_ch,
    input  logic [1:0]  rd_sel,
    output logic [31:0] rd_data,
    input  logic [1:0]  fifo_req,
    output logic        mem_req,
    output logic        mem_we,
    output logic        mem_wide,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        mem_ready,
    output logic [3:0]  irq
);

    logic [AW-1:0]   src_q  [NCH];
    logic [AW-1:0]   dst_q  [NCH];
    logic [15:0]     cnt_q  [NCH];
    logic [15:0]     ctrl_q [NCH];
    logic [NCH-1:0]  pend, grant;
    logic [CH_W-1:0] gnt_id;
    logic            gnt_valid, idle;
    logic            wb_valid, wb_reload, wb_clr_en;
    logic [CH_W-1:0] wb_ch;
    logic [AW-1:0]   wb_src, wb_dst;
    xfer_desc_t      desc;

    dma_regs #(.N(NCH)) u_regs (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .fifo_req(fifo_req), .grant(grant),
        .wb_valid(wb_valid), .wb_ch(wb_ch), .wb_src(wb_src), .wb_dst(wb_dst),
        .wb_reload(wb_reload), .wb_clr_en(wb_clr_en),
        .src_q(src_q), .dst_q(dst_q), .cnt_q(cnt_q), .ctrl_q(ctrl_q), .pend(pend)
    );

    dma_arbiter #(.N(NCH)) u_arb (
        .clk(clk), .rst(rst), .pend(pend), .idle(idle),
        .grant(grant), .gnt_id(gnt_id), .gnt_valid(gnt_valid)
    );

    assign desc = make_desc(gnt_id, src_q[gnt_id], dst_q[gnt_id],
                            cnt_q[gnt_id], ctrl_q[gnt_id]);

    dma_xfer #(.N(NCH)) u_xfer (
        .clk(clk), .rst(rst), .start(gnt_valid), .desc(desc), .idle(idle),
        .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .wb_valid(wb_valid), .wb_ch(wb_ch), .wb_src(wb_src), .wb_dst(wb_dst),
        .wb_reload(wb_reload), .wb_clr_en(wb_clr_en), .irq(irq)
    );

    always_comb begin
        case (reg_sel_e'(rd_sel))
            SEL_SRC:  rd_data = src_q[rd_ch];
            SEL_DST:  rd_data = dst_q[rd_ch];
            SEL_CNT:  rd_data = {16'h0, cnt_q[rd_ch]};
            default:  rd_data = {16'h0, ctrl_q[rd_ch]};
        endcase
    end

endmodule

// File: tb/dma_engine_tb.sv
module dma_engine_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_ch = '0, cfg_sel = '0, rd_ch = '0, rd_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] rd_data;
    logic [1:0]  fifo_req = '0;
    logic        mem_req, mem_we, mem_wide, mem_ready;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  irq;

    int total = 0, bad = 0;
    int cyc = 0;
    bit stall = 1'b1;
    int wr_seen = 0;
    int irq_cnt [4] = '{0, 0, 0, 0};
    logic [3:0] irq_prev = '0;

    typedef struct {
        string       tag;
        logic [31:0] addr;
        logic [31:0] data;
        logic        wide;
    } item_t;
    item_t q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;
    always_ff @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] rd_fn(input logic [31:0] a);
        return {a[15:0] ^ 16'hC3A5, a[31:16] ^ 16'h0F0F};
    endfunction

    assign mem_rdata = rd_fn(mem_addr);
    assign mem_ready = stall ? ((cyc % 3) != 1) : 1'b1;

    dma_engine u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .rd_ch(rd_ch), .rd_sel(rd_sel), .rd_data(rd_data),
        .fifo_req(fifo_req), .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: writes accepted and interrupt pulses
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_req && mem_we && mem_ready) begin
                wr_seen++;
                if (q.size() == 0) begin
                    check(1'b0, "R2 unexpected write addr", mem_addr, 32'hx);
                end else begin
                    item_t it;
                    it = q.pop_front();
                    check(mem_addr == it.addr, {it.tag, " write addr"}, mem_addr, it.addr);
                    check(mem_wdata == it.data, {it.tag, " write data"}, mem_wdata, it.data);
                    check(mem_wide == it.wide, {it.tag, " unit size"}, 32'(mem_wide), 32'(it.wide));
                end
            end
            for (int i = 0; i < 4; i++) begin
                if (irq[i] && !irq_prev[i]) irq_cnt[i]++;
                if (irq[i] && irq_prev[i]) check(1'b0, "R8 irq longer than one cycle", 32'(i), 32'hx);
            end
            irq_prev = irq;
        end
    end

    task automatic cfg(input int ch, input int sel, input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_sel = 2'(sel); cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input int ch, input int sel, output logic [31:0] v);
        rd_ch = 2'(ch); rd_sel = 2'(sel);
        #1 v = rd_data;
    endtask

    task automatic push_run(input string tag, input logic [31:0] src, input logic [31:0] sstep,
                            input logic [31:0] dst, input logic [31:0] dstep,
                            input int n, input bit wide);
        for (int k = 0; k < n; k++) begin
            item_t it;
            it.tag  = tag;
            it.addr = dst;
            it.data = wide ? rd_fn(src) : {16'h0, rd_fn(src)[15:0]};
            it.wide = wide;
            q.push_back(it);
            src = src + sstep;
            dst = dst + dstep;
        end
    endtask

    task automatic wait_drain(input string tag);
        int guard = 0;
        while (q.size() != 0 && guard < 150000) begin
            @(negedge clk);
            guard++;
        end
        check(q.size() == 0, {tag, " expected writes still outstanding"}, 32'(q.size()), 0);
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_fifo(input int idx);
        @(negedge clk);
        fifo_req[idx] = 1'b1;
        @(negedge clk);
        fifo_req[idx] = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", 32'(cyc), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int base;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check(mem_req == 1'b0, "R1 mem_req after reset", 32'(mem_req), 0);
        check(irq == 4'h0, "R1 irq after reset", 32'(irq), 0);
        rd(3, 3, v); check(v == 0, "R1 ctrl3 after reset", v, 0);
        rd(0, 0, v); check(v == 0, "R1 src0 after reset", v, 0);

        // R2 R3 R4 R7: ch3 32-bit, increment both, 3 units, no irq enable
        cfg(3, 0, 32'h0100_0000); cfg(3, 1, 32'h0200_0000); cfg(3, 2, 32'd3);
        push_run("R2 ch3 inc", 32'h0100_0000, 4, 32'h0200_0000, 4, 3, 1'b1);
        cfg(3, 3, 32'h8400);
        wait_drain("R2");
        rd(3, 0, v); check(v == 32'h0100_000C, "R7 ch3 src writeback", v, 32'h0100_000C);
        rd(3, 1, v); check(v == 32'h0200_000C, "R7 ch3 dst writeback", v, 32'h0200_000C);
        rd(3, 3, v); check(v == 32'h0400, "R7 ch3 enable cleared", v, 32'h0400);
        check(irq_cnt[3] == 0, "R8 no irq without enable", 32'(irq_cnt[3]), 0);

        // R3 R5 R6 R8: ch0 16-bit, source decrement, dest fixed, masks, 14-bit count
        cfg(0, 0, 32'hF800_0010); cfg(0, 1, 32'hFFFF_FF00); cfg(0, 2, 32'h0000_C002);
        push_run("R3 R6 ch0 dec/fixed", 32'h0000_0010, -32'sd2, 32'h07FF_FF00, 0, 2, 1'b0);
        cfg(0, 3, 32'hC0C0);
        wait_drain("R3");
        rd(0, 0, v); check(v == 32'h0000_000C, "R6 ch0 src masked writeback", v, 32'h0000_000C);
        rd(0, 1, v); check(v == 32'h07FF_FF00, "R6 ch0 dst masked writeback", v, 32'h07FF_FF00);
        rd(0, 3, v); check(v == 32'h40C0, "R7 ch0 enable cleared", v, 32'h40C0);
        check(irq_cnt[0] == 1, "R8 ch0 irq pulse count", 32'(irq_cnt[0]), 1);

        // R4 destination reload mode on ch2
        cfg(2, 0, 32'h0300_0000); cfg(2, 1, 32'h0400_0000); cfg(2, 2, 32'd2);
        push_run("R4 ch2 reload", 32'h0300_0000, 4, 32'h0400_0000, 4, 2, 1'b1);
        cfg(2, 3, 32'h8460);
        wait_drain("R4");
        rd(2, 1, v); check(v == 32'h0400_0000, "R4 ch2 dst kept", v, 32'h0400_0000);
        rd(2, 0, v); check(v == 32'h0300_0008, "R7 ch2 src updated", v, 32'h0300_0008);

        // R7 repeat keeps enable; R2 rewrite with enable already set does not start
        cfg(3, 0, 32'h0500_0000); cfg(3, 1, 32'h0600_0000); cfg(3, 2, 32'd1);
        push_run("R7 ch3 repeat", 32'h0500_0000, 4, 32'h0600_0000, 4, 1, 1'b1);
        cfg(3, 3, 32'h8600);
        wait_drain("R7");
        rd(3, 3, v); check(v == 32'h8600, "R7 repeat keeps enable", v, 32'h8600);
        base = wr_seen;
        cfg(3, 3, 32'h8600);
        repeat (20) @(negedge clk);
        check(wr_seen == base, "R2 no restart without enable edge", 32'(wr_seen - base), 0);
        cfg(3, 3, 32'h0);

        // R9 refill mode on ch1: forced 4 x 32-bit, fixed dst, source wraps at 28 bits
        cfg(1, 0, 32'hFFFF_FFF0); cfg(1, 1, 32'h1F00_00A0); cfg(1, 2, 32'd7);
        base = wr_seen;
        cfg(1, 3, 32'hF200);
        repeat (15) @(negedge clk);
        check(wr_seen == base, "R9 enable alone does not start refill", 32'(wr_seen - base), 0);
        push_run("R9 ch1 refill", 32'h0FFF_FFF0, 4, 32'h0700_00A0, 0, 4, 1'b1);
        pulse_fifo(0);
        wait_drain("R9");
        rd(1, 0, v); check(v == 32'h0, "R9 ch1 src wraps in 28 bits", v, 0);
        push_run("R9 ch1 refill again", 32'h0, 4, 32'h0700_00A0, 0, 4, 1'b1);
        pulse_fifo(0);
        wait_drain("R9b");
        check(irq_cnt[1] == 2, "R9 ch1 irq per refill", 32'(irq_cnt[1]), 2);
        cfg(1, 3, 32'h0);

        // R10 start field 3 on channel 0
        cfg(0, 2, 32'd1);
        base = wr_seen;
        cfg(0, 3, 32'hF400);
        pulse_fifo(0); pulse_fifo(1);
        repeat (20) @(negedge clk);
        check(wr_seen == base, "R10 ch0 mode 3 makes no writes", 32'(wr_seen - base), 0);
        check(mem_req == 1'b0, "R10 ch0 mode 3 bus idle", 32'(mem_req), 0);
        check(irq_cnt[0] == 1, "R10 ch0 mode 3 no irq", 32'(irq_cnt[0]), 1);
        cfg(0, 3, 32'h0);

        // R11 priority: ch3 runs, then ch2 and ch1 wait; ch1 must go first
        cfg(3, 0, 32'h0700_0000); cfg(3, 1, 32'h0800_0000); cfg(3, 2, 32'd4);
        cfg(2, 0, 32'h0900_0000); cfg(2, 1, 32'h0100_0100); cfg(2, 2, 32'd1);
        cfg(1, 0, 32'h0A00_0000); cfg(1, 1, 32'h0100_0200); cfg(1, 2, 32'd1);
        push_run("R11 ch3 first", 32'h0700_0000, 4, 32'h0800_0000, 4, 4, 1'b1);
        push_run("R11 ch1 before ch2", 32'h0A00_0000, 4, 32'h0100_0200, 4, 1, 1'b1);
        push_run("R11 ch2 last", 32'h0900_0000, 4, 32'h0100_0100, 4, 1, 1'b1);
        cfg(3, 3, 32'h8400);
        cfg(2, 3, 32'h8400);
        cfg(1, 3, 32'h8400);
        wait_drain("R11");

        // R5 zero count means 0x4000 units on ch0 (fixed/fixed, 16-bit)
        stall = 1'b0;
        cfg(0, 0, 32'h0000_0100); cfg(0, 1, 32'h0000_0200); cfg(0, 2, 32'h0);
        base = wr_seen;
        push_run("R5 ch0 zero count", 32'h100, 0, 32'h200, 0, 16384, 1'b0);
        cfg(0, 3, 32'h8140);
        wait_drain("R5");
        check(wr_seen - base == 16384, "R5 ch0 zero count length", 32'(wr_seen - base), 16384);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule